// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit stores the two thresholds that drive the programmable partial flags of a dual-clock FIFO: an empty-side offset and a full-side offset. It compares the word count that the read-side pointer logic supplies against the empty-side offset to drive an almost-empty flag. It compares the word count that the write-side pointer logic supplies against the full-side offset to drive an almost-full flag. Both flags are active low and registered in their own clock domain.

Master reset chooses the programming method and the default offsets from the level of the load pin. Low selects word-wide programming and a default of 127 for both offsets. High selects bit-serial programming and a default of 1023 for both offsets. After reset the offsets are written on write-clock edges, either a whole word at a time or one bit per edge, depending on that method. They can be read back on read-clock edges whatever the method is. Writes and readbacks alternate between the two offsets, and the empty-side offset always comes first. Partial reset returns the alternation to the empty-side offset and keeps the offsets and the method.

The offset registers live in the write-clock domain. The read side samples them directly, so software must not change an offset while the read clock is reading it back or is using it for the almost-empty flag. Readback output is a one-cycle valid strobe with its data word. There is no ready signal, so a readback can never be stalled. Control and status pins are plain levels.

Top module: `aflag_ofs_unit`

## Requirements
- R1: A write-clock edge with mrst_n low and ld low sets both offsets to 127 and selects word-wide programming.
- R2: A write-clock edge with mrst_n low and ld high sets both offsets to 1023 and selects bit-serial programming.
- R3: In word-wide mode, a write-clock edge with ld and wen high stores din into one offset. The first such edge after either reset writes the empty-side offset, and the next writes the full-side offset; after that the order repeats.
- R4: In bit-serial mode, each write-clock edge with ld and sen high stores si into one offset bit. Edges 0 to OFS_W-1 fill the empty-side offset from bit 0 upward. Edges OFS_W to 2*OFS_W-1 fill the full-side offset from bit 0 upward. The edge after those two spans starts at the empty-side offset's bit 0 again.
- R5: A read-clock edge with ld and ren high (and prst_n high) drives dout_vld high for the following cycle. At that edge dout takes the value of the next offset in the sequence, which starts with the empty-side offset and then alternates. At every other edge dout_vld goes low and dout holds its value.
- R6: pae_n is low in the read-clock cycle after an edge at which rd_count was no greater than the empty-side offset, and high otherwise. It is low during master reset.
- R7: paf_n is low in the write-clock cycle after an edge at which wr_count was at least DEPTH minus the full-side offset, and high otherwise. It is high during master reset.
- R8: An edge with prst_n low (and mrst_n high) leaves both offsets and the programming method unchanged. It sends the write order, the serial bit position and the readback order back to the empty-side start.
- R9: The path of the method that is not selected has no effect. In bit-serial mode, wen with ld changes no offset. In word-wide mode, sen with ld changes no offset.
- R10: With ld low, wen, sen and ren change neither an offset nor any order, and no readback is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks |
| ld | input | 1 | Offset access qualifier |
| wen | input | 1 | Word-wide write strobe (write clock) |
| sen | input | 1 | Serial shift strobe (write clock) |
| si | input | 1 | Serial data bit |
| din | input | OFS_W | Offset word for word-wide programming |
| wr_count | input | CNT_W | Stored-word count seen by the write side |
| ren | input | 1 | Readback strobe (read clock) |
| rd_count | input | CNT_W | Stored-word count seen by the read side |
| dout | output | OFS_W | Readback offset word |
| dout_vld | output | 1 | dout carries a fresh readback this cycle |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
Errors in the internal order state appear at the ports in two ways. A wrong write order or readback order shows up at the next readback as swapped offsets. A wrong serial bit position gives a corrupted offset. That offset is seen at the next readback or in the flag one cycle after the count crosses the intended threshold. The reference model tracks the offsets, the method and all three orders at every edge. It compares dout, dout_vld and both flags every cycle, so a deviation is seen within one cycle of the first output it touches. Counts are driven to each threshold and one step past it.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
  // Which offset the next access targets
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/aflag_ofs_store.sv
module aflag_ofs_store
  import aflag_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld,
  input  logic             wen,
  input  logic             sen,
  input  logic             si,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int BIT_N = 2 * OFS_W;
  localparam int BIT_W = $clog2(BIT_N);

  logic             ser_q;
  ofs_sel_e         sel_q, sel_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [OFS_W-1:0] ae_q, ae_d, af_q, af_d;

  always_comb begin
    ae_d  = ae_q;
    af_d  = af_q;
    sel_d = sel_q;
    bit_d = bit_q;
    if (ld) begin
      if (ser_q) begin
        if (sen) begin
          for (int i = 0; i < OFS_W; i++) begin
            if (bit_q == BIT_W'(i))         ae_d[i] = si;
            if (bit_q == BIT_W'(OFS_W + i)) af_d[i] = si;
          end
          bit_d = (bit_q == BIT_W'(BIT_N - 1)) ? '0 : bit_q + 1'b1;
        end
      end else if (wen) begin
        if (sel_q == SEL_EMPTY) ae_d = din;
        else                    af_d = din;
        sel_d = sel_next(sel_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_q <= ld;
      ae_q  <= ld ? OFS_W'(DFLT_SER) : OFS_W'(DFLT_PAR);
      af_q  <= ld ? OFS_W'(DFLT_SER) : OFS_W'(DFLT_PAR);
      sel_q <= SEL_EMPTY;
      bit_q <= '0;
    end else if (!prst_n) begin
      sel_q <= SEL_EMPTY;
      bit_q <= '0;
    end else begin
      ae_q  <= ae_d;
      af_q  <= af_d;
      sel_q <= sel_d;
      bit_q <= bit_d;
    end
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;
endmodule

// File: rtl/aflag_ofs_readback.sv
module aflag_ofs_readback
  import aflag_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld,
  input  logic             ren,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [OFS_W-1:0] dout,
  output logic             dout_vld
);
  ofs_sel_e rsel_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rsel_q   <= SEL_EMPTY;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else if (!prst_n) begin
      rsel_q   <= SEL_EMPTY;
      dout_vld <= 1'b0;
    end else if (ld && ren) begin
      dout     <= (rsel_q == SEL_EMPTY) ? ae_ofs : af_ofs;
      dout_vld <= 1'b1;
      rsel_q   <= sel_next(rsel_q);
    end else begin
      dout_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/aflag_cmp.sv
module aflag_cmp #(
  parameter int CNT_W   = 12,
  parameter int OFS_W   = 10,
  parameter int DEPTH   = 2048,
  parameter bit IS_FULL = 1'b0
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag_n
);
  localparam int SUM_W = CNT_W + 1;

  logic hit;

  generate
    if (IS_FULL) begin : g_full
      // free space within offset: count + ofs >= DEPTH, no underflow
      assign hit = ({1'b0, count} + SUM_W'(ofs)) >= SUM_W'(DEPTH);
    end else begin : g_empty
      assign hit = count <= CNT_W'(ofs);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!mrst_n) flag_n <= IS_FULL;
    else         flag_n <= !hit;
  end
endmodule

// File: rtl/aflag_ofs_unit.sv
module aflag_ofs_unit #(
  parameter int DEPTH    = 2048,
  parameter int OFS_W    = 10,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld,
  input  logic             wen,
  input  logic             sen,
  input  logic             si,
  input  logic [OFS_W-1:0] din,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             ren,
  input  logic [CNT_W-1:0] rd_count,
  output logic [OFS_W-1:0] dout,
  output logic             dout_vld,
  output logic             pae_n,
  output logic             paf_n
);
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  aflag_ofs_store #(
    .OFS_W(OFS_W), .DFLT_PAR(DFLT_PAR), .DFLT_SER(DFLT_SER)
  ) u_store (
    .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
    .wen(wen), .sen(sen), .si(si), .din(din),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  aflag_ofs_readback #(.OFS_W(OFS_W)) u_rb (
    .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .ren(ren),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout), .dout_vld(dout_vld)
  );

  aflag_cmp #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .IS_FULL(1'b0)
  ) u_ae (
    .clk(rclk), .mrst_n(mrst_n), .count(rd_count), .ofs(ae_ofs), .flag_n(pae_n)
  );

  aflag_cmp #(
    .CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .IS_FULL(1'b1)
  ) u_af (
    .clk(wclk), .mrst_n(mrst_n), .count(wr_count), .ofs(af_ofs), .flag_n(paf_n)
  );
endmodule

// File: rtl/aflag_ofs_chk.sv
module aflag_ofs_chk #(
  parameter int OFS_W    = 10,
  parameter int DFLT_PAR = 127,
  parameter int DFLT_SER = 1023
) (
  input logic             wclk,
  input logic             rclk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             ld,
  input logic             ren,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             dout_vld
);
  // R1
  dflt_par_chk: assert property (@(posedge wclk)
    (!mrst_n && !ld) |=> (ae_ofs == OFS_W'(DFLT_PAR) && af_ofs == OFS_W'(DFLT_PAR)));

  // R2
  dflt_ser_chk: assert property (@(posedge wclk)
    (!mrst_n && ld) |=> (ae_ofs == OFS_W'(DFLT_SER) && af_ofs == OFS_W'(DFLT_SER)));

  // R8
  prst_keep_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R10
  ld_idle_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !ld |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R5
  rb_strobe_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (ld && ren && prst_n) |=> dout_vld);

  // R5
  rb_quiet_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    !(ld && ren) |=> !dout_vld);
endmodule

bind aflag_ofs_unit aflag_ofs_chk #(
  .OFS_W(OFS_W), .DFLT_PAR(DFLT_PAR), .DFLT_SER(DFLT_SER)
) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
  .ren(ren), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout_vld(dout_vld)
);

// File: tb/aflag_ofs_unit_tb.sv
`timescale 1ns/1ps
module aflag_ofs_unit_tb;
  localparam int OFS_W = 10;
  localparam int DEPTH = 2048;
  localparam int CNT_W = 12;
  localparam int HI    = 1023;
  localparam int LO    = 127;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic mrst_n = 1'b0, prst_n = 1'b1, ld = 1'b0, wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
  logic [OFS_W-1:0] din = '0;
  logic [CNT_W-1:0] wr_count = '0, rd_count = '0;
  logic [OFS_W-1:0] dout;
  logic dout_vld, pae_n, paf_n;

  aflag_ofs_unit u_dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
    .wen(wen), .sen(sen), .si(si), .din(din), .wr_count(wr_count),
    .ren(ren), .rd_count(rd_count), .dout(dout), .dout_vld(dout_vld),
    .pae_n(pae_n), .paf_n(paf_n)
  );

  int vectors = 0, miscmp = 0;
  string phase = "R1";
  bit started = 0, done = 0;

  // behavioural reference state
  int m_ae = 0, m_af = 0, m_ser = 0, m_wptr = 0, m_bit = 0, m_rptr = 0;
  int m_dout = 0, m_vld = 0, m_pae = 0, m_paf = 1;

  always @(posedge clk) begin
    int o_ae, o_af;
    o_ae = m_ae;
    o_af = m_af;
    if (!mrst_n) begin
      m_ser = ld ? 1 : 0;
      m_ae = ld ? HI : LO;
      m_af = m_ae;
      m_wptr = 0; m_bit = 0; m_rptr = 0;
      m_dout = 0; m_vld = 0; m_pae = 0; m_paf = 1;
    end else begin
      if (!prst_n) begin
        m_wptr = 0; m_bit = 0; m_rptr = 0; m_vld = 0;
      end else begin
        if (ld && m_ser != 0 && sen) begin
          if (m_bit < OFS_W) m_ae = si ? (m_ae | (1 << m_bit)) : (m_ae & ~(1 << m_bit));
          else m_af = si ? (m_af | (1 << (m_bit - OFS_W))) : (m_af & ~(1 << (m_bit - OFS_W)));
          m_bit = (m_bit + 1) % (2 * OFS_W);
        end else if (ld && m_ser == 0 && wen) begin
          if (m_wptr == 0) m_ae = int'(din); else m_af = int'(din);
          m_wptr = 1 - m_wptr;
        end
        if (ld && ren) begin
          m_dout = (m_rptr == 0) ? o_ae : o_af;
          m_vld = 1;
          m_rptr = 1 - m_rptr;
        end else m_vld = 0;
      end
      m_pae = (int'(rd_count) <= o_ae) ? 0 : 1;
      m_paf = (int'(wr_count) + o_af >= DEPTH) ? 0 : 1;
    end
    started = 1;
  end

  task automatic cmp(string sig, int act, int exp);
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", phase, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      cmp("dout_vld(R5)", int'(dout_vld), m_vld);
      cmp("dout(R5)", int'(dout), m_dout);
      cmp("pae_n(R6)", int'(pae_n), m_pae);
      cmp("paf_n(R7)", int'(paf_n), m_paf);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld = 0; wen = 0; sen = 0; ren = 0; si = 0;
    end
  endtask

  task automatic readback(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld = 1; ren = 1; wen = 0; sen = 0;
    end
    idle(1);
  endtask

  task automatic pload(int v);
    @(negedge clk);
    ld = 1; wen = 1; sen = 0; ren = 0; din = OFS_W'(v);
    idle(1);
  endtask

  task automatic sload(int a, int b);
    for (int i = 0; i < 2 * OFS_W; i++) begin
      if (i == 7) idle(1);
      @(negedge clk);
      ld = 1; sen = 1; wen = 0; ren = 0;
      si = (i < OFS_W) ? a[i] : b[i - OFS_W];
    end
    idle(1);
  endtask

  task automatic counts(int rc, int wc);
    @(negedge clk);
    rd_count = CNT_W'(rc); wr_count = CNT_W'(wc);
    idle(2);
  endtask

  task automatic mreset(bit l);
    @(negedge clk);
    mrst_n = 0; ld = l;
    idle(0);
    @(negedge clk);
    @(negedge clk);
    mrst_n = 1; ld = 0;
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscmp++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    // R1: reset with ld low, defaults 127 in word-wide mode
    phase = "R1";
    ld = 0;
    repeat (3) @(negedge clk);
    mrst_n = 1;
    idle(2);
    readback(2);
    // R6 / R7: thresholds around the default offsets
    phase = "R6";
    counts(LO, 0); counts(LO + 1, 0); counts(0, 0);
    phase = "R7";
    counts(2000, DEPTH - LO); counts(2000, DEPTH - LO - 1); counts(2000, DEPTH);
    // R3: word-wide loads alternate empty then full
    phase = "R3";
    pload(5); pload(300); readback(3);
    pload(0); pload(1000); readback(2);
    phase = "R6";
    counts(0, 100); counts(1, 100);
    phase = "R7";
    counts(50, DEPTH - 1000); counts(50, DEPTH - 1001);
    pload(5); pload(300);
    counts(5, DEPTH - 300); counts(6, DEPTH - 301);
    // R9: serial path ignored in word-wide mode
    phase = "R9";
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ld = 1; sen = 1; si = 1;
    end
    idle(1); readback(2);
    // R10: strobes without ld
    phase = "R10";
    @(negedge clk); wen = 1; sen = 1; ren = 1; din = 77;
    @(negedge clk); wen = 1; ren = 1; din = 99;
    idle(1); readback(2);
    // R8: partial reset mid-sequence
    phase = "R8";
    pload(11);
    @(negedge clk); prst_n = 0;
    @(negedge clk); prst_n = 1;
    pload(22); readback(1);
    @(negedge clk); prst_n = 0;
    @(negedge clk); prst_n = 1;
    readback(2);
    // R2: reset with ld high, defaults 1023 in bit-serial mode
    phase = "R2";
    mreset(1'b1);
    readback(2);
    counts(HI, DEPTH - HI); counts(HI + 1, DEPTH - HI - 1);
    // R4: serial load, empty offset first, lsb first
    phase = "R4";
    sload(341, 243); readback(2);
    sload(0, 1023); readback(2);
    phase = "R6";
    counts(0, DEPTH - 1023); counts(1, 1024);
    // R9: word path ignored in serial mode
    phase = "R9";
    pload(12); pload(13); readback(2);
    // R8: partial reset mid serial load restarts at empty bit 0
    phase = "R8";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ld = 1; sen = 1; si = 1;
    end
    @(negedge clk); ld = 0; sen = 0; prst_n = 0;
    @(negedge clk); prst_n = 1;
    sload(600, 17); readback(2);
    // R1 again after serial mode
    phase = "R1";
    mreset(1'b0);
    readback(2);
    // mixed stimulus: R3 R4 R5 R6 R7 R8
    phase = "mix(R3,R4,R5,R6,R7,R8)";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i == 300) begin mrst_n = 0; ld = 1; end
      else begin
        mrst_n = 1;
        prst_n = ($urandom % 20) != 0;
        ld  = ($urandom % 3) != 0;
        wen = $urandom % 2;
        sen = $urandom % 2;
        si  = $urandom % 2;
        ren = $urandom % 2;
        din = OFS_W'($urandom);
        rd_count = CNT_W'($urandom % 1100);
        wr_count = CNT_W'(DEPTH - ($urandom % 1100));
      end
    end
    mrst_n = 1; prst_n = 1;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule